// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block sits beside a small processor core and decides when, and to which handler, the core branches on an interrupt. It watches a set of level-sensitive request lines from peripherals plus one non-maskable request. It tracks the core's global interrupt enable bit and listens for two pulses from the core: one for each retired instruction and one for each return from a handler. When a request may be taken, the block picks the winner by fixed priority, acknowledges it, and runs a fixed five-cycle entry sequence. The first two cycles write out the return address as two halves. The last cycle tells the core to jump to the winner's vector slot.

Each handler slot in the vector table is two words long. The non-maskable request owns the first slot and maskable line k owns slot k+1, so a lower slot address always means a higher priority. Taking an interrupt clears the global enable unless nesting is selected. A return sets it again. After any return, the core must retire one instruction of the interrupted code before the block starts another entry.

Top module: `vec_irq_ctrl`

## Requirements
- R1: Among the maskable lines that are requesting, the lowest index wins. Its bit in `irq_ack_o` pulses for exactly one cycle, and at most one acknowledge bit (maskable or non-maskable) is ever high at once.
- R2: The jump target is `VEC_BASE` for the non-maskable request and `VEC_BASE + 2*(k+1)` for maskable line k.
- R3: A maskable line is taken only while `gie_o` is 1. The non-maskable request is taken whatever the state of `gie_o`, and it wins over every maskable line.
- R4: Counting from the clock edge that accepts a request, the five cycles that follow are: acknowledge with the first save write; the second save write; two cycles with neither save nor jump; and a one-cycle `jump_o` with `jump_addr_o` valid.
- R5: The two save writes carry `next_pc_i` as it was sampled on the accepting edge: the low half `[ADDR_W/2-1:0]` first, then the high half.
- R6: `gie_o` resets to 0. `gie_set_i` sets it and `gie_clr_i` clears it; when both arrive in the same cycle, the clear wins.
- R7: Accepting a request clears `gie_o`, except while `nest_en_i` is 1, when `gie_o` keeps its value.
- R8: `reti_i` sets `gie_o`.
- R9: After `reti_i`, no entry starts until `retire_i` has pulsed in a later cycle.
- R10: A request that arrives during an entry does not change the running sequence or its jump target. It is arbitrated once the sequence ends.
- R11: `busy_o` is 1 during exactly the five cycles of an entry, and it is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | NUM_LINES | Level-sensitive maskable requests; bit 0 has the highest priority |
| nmi_i | input | 1 | Non-maskable request, level-sensitive |
| gie_set_i | input | 1 | Pulse that sets the global enable |
| gie_clr_i | input | 1 | Pulse that clears the global enable |
| nest_en_i | input | 1 | 1 keeps the global enable unchanged on entry |
| retire_i | input | 1 | Pulse for each retired instruction |
| reti_i | input | 1 | Pulse for each return from a handler |
| next_pc_i | input | ADDR_W | Address of the next instruction not yet executed |
| irq_ack_o | output | NUM_LINES | One-cycle acknowledge to the winning maskable line |
| nmi_ack_o | output | 1 | One-cycle acknowledge to the non-maskable source |
| busy_o | output | 1 | Entry sequence in progress |
| ret_we_o | output | 1 | Write strobe for the return address halves |
| ret_data_o | output | ADDR_W/2 | Return address half being written |
| jump_o | output | 1 | One-cycle command to jump |
| jump_addr_o | output | ADDR_W | Vector slot address for the jump |
| gie_o | output | 1 | Current global interrupt enable |

## Verification
The assertions assume that sources hold their request level until they see their acknowledge, and that `reti_i` and `retire_i` are single-cycle pulses timed the way a core would issue them. The bench models the peripherals by dropping each request in the cycle its acknowledge is seen. It always issues a return, and then a retire, before it expects the next entry. It drives every input a short delay after the rising edge. A table of request patterns covers the arbitration, masking and vector cases. Directed sequences then cover nesting, the guard after a return, and a request that arrives in the middle of an entry.

// File: rtl/vic_pkg.sv
package vic_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_SAVE_LO = 3'd1,
      ST_SAVE_HI = 3'd2,
      ST_JMP_A   = 3'd3,
      ST_JMP_B   = 3'd4,
      ST_JMP_C   = 3'd5
   } entry_state_e;

endpackage

// File: rtl/vic_prio_arb.sv
module vic_prio_arb #(
   parameter int NUM_LINES = 8,
   parameter int IDX_W     = 3
) (
   input  logic [NUM_LINES-1:0] req_i,
   output logic [NUM_LINES-1:0] grant_o,
   output logic [IDX_W-1:0]     idx_o,
   output logic                 any_o
);

   logic [NUM_LINES:0] blocked;

   assign blocked[0] = 1'b0;

   for (genvar k = 0; k < NUM_LINES; k++) begin : g_chain
      assign grant_o[k]   = req_i[k] & ~blocked[k];
      assign blocked[k+1] = blocked[k] | req_i[k];
   end

   assign any_o = blocked[NUM_LINES];

   always_comb begin
      idx_o = '0;
      for (int k = 0; k < NUM_LINES; k++) begin
         if (grant_o[k]) idx_o = idx_o | IDX_W'(k);
      end
   end

endmodule

// File: rtl/vic_enable_ctl.sv
module vic_enable_ctl (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic set_i,
   input  logic clr_i,
   input  logic reti_i,
   input  logic retire_i,
   input  logic take_i,
   input  logic nest_i,
   output logic gie_o,
   output logic guard_o
);

   logic gie_q, guard_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         gie_q <= 1'b0;
      end else if (take_i && !nest_i) begin
         gie_q <= 1'b0;
      end else if (clr_i) begin
         gie_q <= 1'b0;
      end else if (set_i || reti_i) begin
         gie_q <= 1'b1;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         guard_q <= 1'b0;
      end else if (reti_i) begin
         guard_q <= 1'b1;
      end else if (retire_i) begin
         guard_q <= 1'b0;
      end
   end

   assign gie_o   = gie_q;
   assign guard_o = guard_q;

   assert_entry_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (take_i && !nest_i) |=> !gie_o);

   assert_reti_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reti_i && !take_i && !clr_i) |=> gie_o);

   assert_clr_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && set_i) |=> !gie_o);

endmodule

// File: rtl/vic_entry_seq.sv
module vic_entry_seq
   import vic_pkg::*;
#(
   parameter int NUM_LINES = 8,
   parameter int ADDR_W    = 16
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  take_i,
   input  logic                  nmi_win_i,
   input  logic [NUM_LINES-1:0]  grant_i,
   input  logic [ADDR_W-1:0]     vec_i,
   input  logic [ADDR_W-1:0]     pc_i,
   output logic                  idle_o,
   output logic [NUM_LINES-1:0]  ack_o,
   output logic                  nmi_ack_o,
   output logic                  ret_we_o,
   output logic [ADDR_W/2-1:0]   ret_data_o,
   output logic                  jump_o,
   output logic [ADDR_W-1:0]     jump_addr_o
);

   localparam int HALF_W = ADDR_W / 2;

   entry_state_e         state_q, state_d;
   logic [NUM_LINES-1:0] grant_q;
   logic                 nmi_q;
   logic [ADDR_W-1:0]    pc_q, vec_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:    if (take_i) state_d = ST_SAVE_LO;
         ST_SAVE_LO: state_d = ST_SAVE_HI;
         ST_SAVE_HI: state_d = ST_JMP_A;
         ST_JMP_A:   state_d = ST_JMP_B;
         ST_JMP_B:   state_d = ST_JMP_C;
         ST_JMP_C:   state_d = ST_IDLE;
         default:    state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         grant_q <= '0;
         nmi_q   <= 1'b0;
         pc_q    <= '0;
         vec_q   <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && take_i) begin
            grant_q <= nmi_win_i ? '0 : grant_i;
            nmi_q   <= nmi_win_i;
            pc_q    <= pc_i;
            vec_q   <= vec_i;
         end
      end
   end

   assign idle_o      = (state_q == ST_IDLE);
   assign ack_o       = (state_q == ST_SAVE_LO) ? grant_q : '0;
   assign nmi_ack_o   = (state_q == ST_SAVE_LO) && nmi_q;
   assign ret_we_o    = (state_q == ST_SAVE_LO) || (state_q == ST_SAVE_HI);
   assign ret_data_o  = (state_q == ST_SAVE_HI) ? pc_q[ADDR_W-1:HALF_W] : pc_q[HALF_W-1:0];
   assign jump_o      = (state_q == ST_JMP_C);
   assign jump_addr_o = vec_q;

   assert_save_pair_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ret_we_o) |=> ret_we_o);

   assert_jump_spacing_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      jump_o |-> ($past(ret_we_o, 3) && !$past(ret_we_o, 2) && !$past(ret_we_o)));

   assert_target_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!idle_o && !$past(idle_o)) |-> $stable(jump_addr_o));

endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
   parameter int              NUM_LINES = 8,
   parameter int              ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic [NUM_LINES-1:0]  irq_i,
   input  logic                  nmi_i,
   input  logic                  gie_set_i,
   input  logic                  gie_clr_i,
   input  logic                  nest_en_i,
   input  logic                  retire_i,
   input  logic                  reti_i,
   input  logic [ADDR_W-1:0]     next_pc_i,
   output logic [NUM_LINES-1:0]  irq_ack_o,
   output logic                  nmi_ack_o,
   output logic                  busy_o,
   output logic                  ret_we_o,
   output logic [ADDR_W/2-1:0]   ret_data_o,
   output logic                  jump_o,
   output logic [ADDR_W-1:0]     jump_addr_o,
   output logic                  gie_o
);

   localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

   if (NUM_LINES < 1 || NUM_LINES > 64) begin : g_bad_lines
      $error("NUM_LINES must lie in 1..64");
   end
   if (ADDR_W < 4 || (ADDR_W % 2) != 0) begin : g_bad_addr
      $error("ADDR_W must be even and at least 4");
   end

   logic [NUM_LINES-1:0] masked, grant;
   logic [IDX_W-1:0]     win_idx;
   logic                 any_masked, idle, guard, take, gie;
   logic [ADDR_W-1:0]    vec;

   assign masked = irq_i & {NUM_LINES{gie}};

   vic_prio_arb #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) arb_i (
      .req_i   (masked),
      .grant_o (grant),
      .idx_o   (win_idx),
      .any_o   (any_masked)
   );

   assign take = idle && !guard && (nmi_i || any_masked);
   assign vec  = nmi_i ? VEC_BASE
                       : VEC_BASE + ADDR_W'(2 * (int'(win_idx) + 1));

   vic_enable_ctl en_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .set_i    (gie_set_i),
      .clr_i    (gie_clr_i),
      .reti_i   (reti_i),
      .retire_i (retire_i),
      .take_i   (take),
      .nest_i   (nest_en_i),
      .gie_o    (gie),
      .guard_o  (guard)
   );

   vic_entry_seq #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) seq_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .take_i      (take),
      .nmi_win_i   (nmi_i),
      .grant_i     (grant),
      .vec_i       (vec),
      .pc_i        (next_pc_i),
      .idle_o      (idle),
      .ack_o       (irq_ack_o),
      .nmi_ack_o   (nmi_ack_o),
      .ret_we_o    (ret_we_o),
      .ret_data_o  (ret_data_o),
      .jump_o      (jump_o),
      .jump_addr_o (jump_addr_o)
   );

   assign busy_o = !idle;
   assign gie_o  = gie;

   assert_ack_single_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({irq_ack_o, nmi_ack_o}));

   assert_ack_lowest_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_ack_o != '0) |-> ((($past(irq_i) & (irq_ack_o - 1'b1)) == '0)
                             && ((irq_ack_o & ~$past(irq_i)) == '0)));

   assert_mask_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(busy_o) |-> (nmi_ack_o || $past(gie_o)));

   assert_guard_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(busy_o) |-> !$past(guard));

   assert_busy_span_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      jump_o |=> !busy_o);

endmodule

// File: tb/vec_irq_ctrl_tb_top.sv
module vec_irq_ctrl_tb_top;

   localparam logic [15:0] BASE = 16'h0100;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [7:0]  irq;
   logic        nmi, gset, gclr, nest, retire, reti;
   logic [15:0] npc;
   logic [7:0]  irq_ack_o;
   logic        nmi_ack_o, busy_o, ret_we_o, jump_o, gie_o;
   logic [7:0]  ret_data_o;
   logic [15:0] jump_addr_o;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   vec_irq_ctrl #(.NUM_LINES(8), .ADDR_W(16), .VEC_BASE(BASE)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .nmi_i(nmi),
      .gie_set_i(gset), .gie_clr_i(gclr), .nest_en_i(nest),
      .retire_i(retire), .reti_i(reti), .next_pc_i(npc),
      .irq_ack_o(irq_ack_o), .nmi_ack_o(nmi_ack_o), .busy_o(busy_o),
      .ret_we_o(ret_we_o), .ret_data_o(ret_data_o), .jump_o(jump_o),
      .jump_addr_o(jump_addr_o), .gie_o(gie_o)
   );

   // fields: [19:12] requests, [11] nmi, [10] enable, [9] taken, [8] nmi ack, [7:0] line ack
   localparam logic [19:0] TBL [7] = '{
      {8'h01, 1'b0, 1'b1, 1'b1, 1'b0, 8'h01},
      {8'hB4, 1'b0, 1'b1, 1'b1, 1'b0, 8'h04},
      {8'h80, 1'b0, 1'b1, 1'b1, 1'b0, 8'h80},
      {8'h0A, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00},
      {8'h30, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
      {8'hFF, 1'b0, 1'b1, 1'b1, 1'b0, 8'h01},
      {8'h01, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00}
   };

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   function automatic logic [15:0] exp_vec(input logic en, input logic [7:0] ack);
      logic [15:0] v;
      v = BASE;
      if (!en) begin
         for (int k = 0; k < 8; k++) if (ack[k]) v = BASE + 16'(2 * (k + 1));
      end
      return v;
   endfunction

   task automatic pulse_set();    gset = 1'b1;   step(); gset = 1'b0;   endtask
   task automatic pulse_clr();    gclr = 1'b1;   step(); gclr = 1'b0;   endtask
   task automatic pulse_reti();   reti = 1'b1;   step(); reti = 1'b0;   endtask
   task automatic pulse_retire(); retire = 1'b1; step(); retire = 1'b0; endtask

   task automatic do_entry(input logic [7:0] eack, input logic enmi, input logic [15:0] pc, input logic egie);
      int w = 0;
      while (irq_ack_o == 8'h00 && !nmi_ack_o && w < 10) begin
         step();
         w++;
      end
      chk(irq_ack_o == eack, "R1 ack", irq_ack_o, eack);
      chk(nmi_ack_o == enmi, "R3 nmi ack", nmi_ack_o, enmi);
      chk(ret_we_o && ret_data_o == pc[7:0], "R5 low half", ret_data_o, pc[7:0]);
      chk(busy_o, "R11 busy", busy_o, 1);
      chk(gie_o == egie, "R7 enable on entry", gie_o, egie);
      irq = irq & ~irq_ack_o;
      if (nmi_ack_o) nmi = 1'b0;
      step();
      chk(ret_we_o && ret_data_o == pc[15:8], "R5 high half", ret_data_o, pc[15:8]);
      chk(irq_ack_o == 8'h00 && !nmi_ack_o, "R1 ack one cycle", irq_ack_o, 0);
      step();
      chk(!ret_we_o && !jump_o, "R4 gap", {ret_we_o, jump_o}, 0);
      step();
      chk(!ret_we_o && !jump_o && busy_o, "R4 gap", {busy_o, ret_we_o, jump_o}, 3'b100);
      step();
      chk(jump_o && jump_addr_o == exp_vec(enmi, eack), "R2 R4 jump", jump_addr_o, exp_vec(enmi, eack));
      step();
      chk(!busy_o && !jump_o, "R11 idle", {busy_o, jump_o}, 0);
   endtask

   initial begin
      #(20 * 200000);
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      rst_n = 1'b0; irq = '0; nmi = 1'b0; gset = 1'b0; gclr = 1'b0;
      nest = 1'b0; retire = 1'b0; reti = 1'b0; npc = '0;
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      step();
      chk(!gie_o && !busy_o && irq_ack_o == 0 && !jump_o && !ret_we_o, "R6 reset",
          {gie_o, busy_o, jump_o, ret_we_o}, 0);

      for (int r = 0; r < 7; r++) begin
         logic [19:0] e;
         logic [15:0] pc;
         e  = TBL[r];
         pc = 16'h1230 + 16'(r * 16'h0111);
         if (e[10]) pulse_set(); else pulse_clr();
         chk(gie_o == e[10], "R6 set/clear", gie_o, e[10]);
         npc = pc;
         irq = e[19:12];
         nmi = e[11];
         if (e[9]) begin
            do_entry(e[7:0], e[8], pc, 1'b0);
            irq = '0;
            nmi = 1'b0;
            pulse_reti();
            chk(gie_o, "R8 return sets enable", gie_o, 1);
            pulse_retire();
         end else begin
            repeat (8) step();
            chk(!busy_o && irq_ack_o == 0, "R3 masked lines ignored", irq_ack_o, 0);
            irq = '0;
         end
      end

      // R6: clear wins over set
      pulse_set();
      gset = 1'b1; gclr = 1'b1;
      step();
      gset = 1'b0; gclr = 1'b0;
      chk(!gie_o, "R6 clear wins", gie_o, 0);

      // R7: nesting keeps the enable
      nest = 1'b1;
      pulse_set();
      npc = 16'hBEEF;
      irq = 8'h08;
      do_entry(8'h08, 1'b0, 16'hBEEF, 1'b1);
      irq = '0;
      pulse_reti();
      pulse_retire();
      nest = 1'b0;

      // R9: guard after return
      pulse_set();
      pulse_reti();
      npc = 16'h4567;
      irq = 8'h04;
      repeat (4) step();
      chk(irq_ack_o == 0 && !busy_o, "R9 guard holds off entry", irq_ack_o, 0);
      pulse_retire();
      do_entry(8'h04, 1'b0, 16'h4567, 1'b0);
      irq = '0;
      pulse_reti();
      pulse_retire();

      // R10: request arriving mid-entry
      pulse_set();
      npc = 16'h9A0C;
      irq = 8'h20;
      begin
         int w = 0;
         while (irq_ack_o == 8'h00 && w < 10) begin step(); w++; end
      end
      chk(irq_ack_o == 8'h20, "R10 first winner", irq_ack_o, 8'h20);
      irq = 8'h01;
      repeat (4) step();
      chk(jump_o && jump_addr_o == BASE + 16'd12, "R10 target unchanged", jump_addr_o, BASE + 16'd12);
      repeat (3) step();
      chk(!busy_o && irq_ack_o == 0, "R10 late request waits", busy_o, 0);
      npc = 16'h0F0E;
      pulse_reti();
      pulse_retire();
      do_entry(8'h01, 1'b0, 16'h0F0E, 1'b0);
      irq = '0;
      pulse_reti();
      pulse_retire();

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule